// File: doc/BRIEF.md
# Strap-Configured Audio Frame Clock Generator

This block takes the audio master clock and derives two serial-port clocks from it: a frame clock that runs at the sample rate, and a bit clock that runs at 64 times the sample rate. Two mode straps choose the speed class. A fast-clock select adds a divide-by-2 in front of the chain for a master clock that is twice the normal ratio. The strap code 11 makes the device a clock slave. In that case the block stops driving its outputs and deasserts the pin-drive control, so that an external source can own both lines.

Straps and the fast select are sampled only while reset is held. Every divider starts from zero on the same master-clock edge. Several devices released by the same reset edge therefore keep their frames aligned. In the fastest class with normal prescale, the bit clock has the same rate as the master clock. It is then the inverted master clock passed through an AND gate, and the gate's enable is a register.

The block has no data interface. All of its pins are plain control or clock signals, with no flow control.

Top module: `aclk_clock_gen`

## Requirements
- R1: The strap code {mode_hi_i, mode_lo_i} decodes as follows: 00 = master single speed, 01 = master double speed, 10 = master quad speed, 11 = slave. The three master codes give a frame clock period of 256, 128 and 64 master clocks at normal prescale.
- R2: In master mode, lrck_o has a period of 2^(6+k) master clocks and a 50% duty cycle. k is 2, 1 or 0 for single, double or quad speed, plus 1 when the captured fast select is 1.
- R3: In master mode with k>0, sclk_o has a period of 2^k master clocks and a 50% duty cycle, which gives 64 bit-clock periods per frame.
- R4: Every transition of lrck_o happens on the same master-clock rising edge as a falling edge of sclk_o.
- R5: While reset is low, lrck_o and sclk_o are 0. Counting starts at the first master-clock rising edge that sees rst_ni high. lrck_o stays low for the first half frame and first rises 2^(5+k) edges after counting starts.
- R6: In slave mode (code 11), lrck_o, sclk_o, pin_drive_o and master_active_o are all 0.
- R7: The straps and fast_i are captured on each master-clock rising edge while rst_ni is low. Any change to them while rst_ni is high has no effect on the outputs.
- R8: In quad speed with normal prescale (k=0), sclk_o is 0 while the master clock is high. While the master clock is low, sclk_o equals an enable register that is 0 in reset and 1 from the first running edge on.
- R9: pin_drive_o is 1 whenever the captured mode is a master mode, including during reset. master_active_o is 1 only in a master mode after counting has started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Audio master clock; all registers use its rising edge |
| rst_ni | input | 1 | Active-low synchronous reset; straps are sampled while it is low |
| mode_hi_i | input | 1 | Upper mode strap |
| mode_lo_i | input | 1 | Lower mode strap |
| fast_i | input | 1 | 1 selects the extra divide-by-2 prescale |
| lrck_o | output | 1 | Frame (left/right) clock at the sample rate |
| sclk_o | output | 1 | Serial bit clock at 64 times the sample rate |
| master_active_o | output | 1 | High while generating clocks as master |
| pin_drive_o | output | 1 | Output-buffer enable for the two clock pins; 0 means the pins are inputs |

## Verification
The bench goes after the frame boundaries in all eight strap and prescale combinations. A divider tapped at the wrong bit would show a wrong first-rise cycle or a wrong period between rises. A frame clock derived from an edge off by one would change away from a bit-clock fall. The direct bit-clock path is checked in both master-clock phases: a gate opened too early would toggle during reset, and a plain clock mux would stay high through the high phase. The bench also flips the straps during reset and again mid-run. A design that kept sampling after release would change its frame length partway through a run. Slave runs confirm that nothing is driven.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_DOUBLE = 2'b01,
    MODE_QUAD   = 2'b10,
    MODE_SLAVE  = 2'b11
  } aclk_mode_e;

  typedef struct packed {
    aclk_mode_e mode;
    logic       fast;
  } aclk_cfg_t;

  // log2 of the bit-clock divide before prescale
  function automatic logic [1:0] speed_shift(aclk_mode_e m);
    case (m)
      MODE_SINGLE: speed_shift = 2'd2;
      MODE_DOUBLE: speed_shift = 2'd1;
      default:     speed_shift = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/aclk_strap_capture.sv
module aclk_strap_capture
  import aclk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      mode_hi_i,
  input  logic      mode_lo_i,
  input  logic      fast_i,
  output aclk_cfg_t cfg_o
);

  aclk_cfg_t cfg_q;

  // transparent sampling while reset is held, frozen afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cfg_q.mode <= aclk_mode_e'({mode_hi_i, mode_lo_i});
      cfg_q.fast <= fast_i;
    end
  end

  assign cfg_o = cfg_q;

  AST_STRAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(cfg_q)); // R7

endmodule

// File: rtl/aclk_div_counter.sv
module aclk_div_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  // single shared counter: every divider tap restarts on the same edge
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      run_q <= 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = run_q;

  AST_COUNT_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

endmodule

// File: rtl/aclk_tap_select.sv
module aclk_tap_select
  import aclk_pkg::*;
#(
  parameter int FRAME_LOG = 6,
  parameter int MAX_SHIFT = 3,
  parameter int CNT_W     = FRAME_LOG + MAX_SHIFT
) (
  input  aclk_cfg_t        cfg_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             lr_bit_o,
  output logic             sc_bit_o,
  output logic             direct_o
);

  localparam int SHIFT_W = $clog2(MAX_SHIFT + 1);

  logic [SHIFT_W-1:0] k;

  assign k = SHIFT_W'(speed_shift(cfg_i.mode)) + SHIFT_W'(cfg_i.fast);

  // bit clock = counter bit k-1, frame clock = bit FRAME_LOG-1+k;
  // both flip on the same wrap of the lower bits
  always_comb begin
    lr_bit_o = cnt_i[FRAME_LOG-1];
    sc_bit_o = 1'b0;
    for (int i = 1; i <= MAX_SHIFT; i++) begin
      if (k == SHIFT_W'(i)) begin
        lr_bit_o = cnt_i[FRAME_LOG-1+i];
        sc_bit_o = cnt_i[i-1];
      end
    end
  end

  assign direct_o = (cfg_i.mode == MODE_QUAD) && !cfg_i.fast;

endmodule

// File: rtl/aclk_sclk_gate.sv
module aclk_sclk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic direct_i,
  input  logic sc_bit_i,
  output logic sclk_o
);

  logic en_q;

  // enable changes just after a rising edge, while ~clk is already low
  always_ff @(posedge clk_i) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= direct_i;
  end

  assign sclk_o = direct_i ? (~clk_i & en_q) : sc_bit_i;

  AST_GATE_DIRECT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> direct_i); // R8

endmodule

// File: rtl/aclk_clock_gen.sv
module aclk_clock_gen
  import aclk_pkg::*;
#(
  parameter int FRAME_LOG = 6,
  parameter int MAX_SHIFT = 3
) (
  input  logic mclk_i,
  input  logic rst_ni,
  input  logic mode_hi_i,
  input  logic mode_lo_i,
  input  logic fast_i,
  output logic lrck_o,
  output logic sclk_o,
  output logic master_active_o,
  output logic pin_drive_o
);

  localparam int CNT_W = FRAME_LOG + MAX_SHIFT;

  aclk_cfg_t        cfg;
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             lr_bit;
  logic             sc_bit;
  logic             direct;
  logic             sclk_raw;
  logic             is_master;

  aclk_strap_capture u_strap (
    .clk_i     (mclk_i),
    .rst_ni    (rst_ni),
    .mode_hi_i (mode_hi_i),
    .mode_lo_i (mode_lo_i),
    .fast_i    (fast_i),
    .cfg_o     (cfg)
  );

  aclk_div_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (mclk_i),
    .rst_ni    (rst_ni),
    .cnt_o     (cnt),
    .running_o (running)
  );

  aclk_tap_select #(
    .FRAME_LOG (FRAME_LOG),
    .MAX_SHIFT (MAX_SHIFT),
    .CNT_W     (CNT_W)
  ) u_tap (
    .cfg_i    (cfg),
    .cnt_i    (cnt),
    .lr_bit_o (lr_bit),
    .sc_bit_o (sc_bit),
    .direct_o (direct)
  );

  aclk_sclk_gate u_gate (
    .clk_i    (mclk_i),
    .rst_ni   (rst_ni),
    .direct_i (direct),
    .sc_bit_i (sc_bit),
    .sclk_o   (sclk_raw)
  );

  assign is_master       = (cfg.mode != MODE_SLAVE);
  assign pin_drive_o     = is_master;
  assign master_active_o = is_master && running;
  assign lrck_o          = is_master && lr_bit;
  assign sclk_o          = is_master && sclk_raw;

  AST_SLAVE_SILENT: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (cfg.mode == MODE_SLAVE) |-> (!lrck_o && !sclk_o && !pin_drive_o)); // R6

  AST_LR_ON_SCLK_FALL: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    ((lrck_o != $past(lrck_o)) && !direct) |-> (!sclk_o && $past(sclk_o))); // R4

  AST_FIRST_HALF_LOW: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    $rose(master_active_o) |-> !lrck_o); // R5

  AST_ACTIVE_DRIVES: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    master_active_o |-> pin_drive_o); // R9

endmodule

// File: tb/aclk_clock_gen_bench.sv
`timescale 1ns/1ps
module aclk_clock_gen_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic hi = 1'b0, lo = 1'b0, fast = 1'b0;
  logic lrck, sclk, mact, drive;

  aclk_clock_gen u_aclk_clock_gen (
    .mclk_i          (clk),
    .rst_ni          (rst_n),
    .mode_hi_i       (hi),
    .mode_lo_i       (lo),
    .fast_i          (fast),
    .lrck_o          (lrck),
    .sclk_o          (sclk),
    .master_active_o (mact),
    .pin_drive_o     (drive)
  );

  int n_chk = 0, n_bad = 0;
  int n = 0;
  int m_mode = 0, m_fast = 0;
  int rise1 = -1, rise2 = -1;
  logic prev_lr = 1'b0, prev_sc = 1'b0;
  bit done = 0;

  function automatic int kval(int mode, int f);
    case (mode)
      0: return 2 + f;
      1: return 1 + f;
      default: return f;
    endcase
  endfunction

  task automatic chk(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b (mode=%0d fast=%0d n=%0d)",
               tag, what, act, exp, m_mode, m_fast, n);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (mode=%0d fast=%0d)",
               tag, what, act, exp, m_mode, m_fast);
    end
  endtask

  // one master-clock cycle of reference model plus comparison in both phases
  task automatic step();
    bit master, direct;
    int k;
    logic e_lr, e_sc;
    @(posedge clk);
    if (!rst_n) begin
      m_mode = {hi, lo};
      m_fast = fast;
      n = 0;
    end else begin
      n++;
    end
    #5;
    master = (m_mode != 3);
    k = kval(m_mode, m_fast);
    direct = master && (k == 0);
    e_lr = master && (((n >> (5 + k)) & 1) == 1);
    e_sc = master && (k > 0) && (((n >> (k - 1)) & 1) == 1);
    chk(master ? "R2" : "R6", lrck, e_lr, "lrck");
    chk(direct ? "R8" : (master ? "R3" : "R6"), sclk, e_sc, "sclk high phase");
    chk(master ? "R9" : "R6", drive, master, "pin_drive");
    chk(master ? "R9" : "R6", mact, master && (n >= 1), "master_active");
    if (rst_n && master && !direct && (lrck !== prev_lr))
      chk("R4", (prev_sc === 1'b1) && (sclk === 1'b0), 1'b1, "lrck edge on sclk fall");
    if (rst_n && lrck === 1'b1 && prev_lr === 1'b0) begin
      if (rise1 < 0) rise1 = n;
      else if (rise2 < 0) rise2 = n;
    end
    prev_lr = lrck;
    prev_sc = sclk;
    @(negedge clk);
    #5;
    if (direct) chk("R8", sclk, (n >= 1), "sclk low phase");
    else        chk(master ? "R3" : "R6", sclk, e_sc, "sclk low phase");
  endtask

  task automatic run_case(int mode, int f);
    int k, total;
    rst_n = 1'b0;
    {hi, lo} = 2'(~mode);
    fast = ~f[0];
    step();
    {hi, lo} = 2'(mode);
    fast = f[0];
    step();
    step();
    chk("R5", lrck, 1'b0, "lrck in reset");
    chk("R5", mact, 1'b0, "master_active in reset");
    rise1 = -1;
    rise2 = -1;
    prev_lr = 1'b0;
    prev_sc = 1'b0;
    k = kval(mode, f);
    total = (mode == 3) ? 200 : (1 << (7 + k)) + 20;
    rst_n = 1'b1;
    for (int c = 0; c < total; c++) begin
      if (c == 40) begin
        {hi, lo} = 2'(mode + 1);
        fast = ~f[0];
      end
      step();
    end
    if (mode != 3) begin
      chk_int("R5", rise1, 1 << (5 + k), "first lrck rise edge count");
      chk_int("R1", rise2 - rise1, 1 << (6 + k), "frame period after R7 strap change");
    end else begin
      chk_int("R6", rise1, -1, "slave lrck rises");
    end
  endtask

  initial begin
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 2; f++)
        run_case(m, f);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule